// File: doc/BRIEF.md
# Half-Warp Global Memory Coalescer

This block takes one memory request from a group of 16 threads and turns it into the smallest set of aligned segment transactions that the memory side must serve. The request carries 16 byte addresses, a per-thread active flag, a word size of 4 or 8 bytes and a mode bit. The block accepts a request only while it is idle. It then issues the transactions one after another under a valid/ready handshake. After the last transaction it gives a one-cycle completion pulse.

Two grouping rules are available. The strict rule recognises only one pattern: the active threads hit consecutive words of a single block that is aligned to sixteen words. A request that matches is served by one transaction. Any other request falls back to one 32-byte transaction for each active thread. The relaxed rule puts all active threads that fall in the same 128-byte block into one transaction. It then shrinks that transaction to a 64- or 32-byte segment when the requested bytes fit inside one. Each transaction carries a byte mask, so the memory side knows which bytes are really wanted.

Top module: `coal_top`

## Requirements
- R1: During reset and in the first cycle after it, `req_ready` is 1 and `tx_valid` and `done` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after the completion pulse. While idle, `tx_valid` and `done` are 0.
- R3: Strict mode (`req_relaxed`=0). Let j be the lowest active thread and B = addr[j] − j·W, where W is the word size. If B is a multiple of 16·W and every active thread k has addr[k] = B + k·W, exactly one transaction is issued. Its base is B and its size is 64 bytes for W=4 or 128 bytes for W=8. Its mask sets bytes k·W to k·W+W−1 for each active k.
- R4: In strict mode, any other request (misaligned, strided, permuted) issues one transaction per active thread. Each has size 32 bytes and base addr & ~31, and its mask sets W bits starting at bit addr mod 32.
- R5: Relaxed mode (`req_relaxed`=1) issues one transaction per distinct 128-byte block touched by active threads. The mask is the union of the threads' bytes, so repeated addresses merge. The segment is 32 bytes if those bytes lie in one aligned 32-byte quarter. Otherwise it is 64 bytes if they lie in one aligned half. Otherwise it is 128 bytes. The base is the start of the chosen segment.
- R6: Transactions come out in ascending order of base address. In the strict per-thread fallback, equal addresses are issued in ascending thread index.
- R7: Inactive threads never affect the transactions. A request with no active thread issues no transaction, only the completion pulse.
- R8: While `tx_valid`=1 and `tx_ready`=0, `tx_base`, `tx_size` and `tx_mask` hold their values. The next transaction appears in the cycle after a handshake.
- R9: `done` is 1 for exactly one cycle: the cycle after the last handshake, or the cycle after acceptance when nothing is issued. `tx_valid` is 0 in that cycle.
- R10: `tx_size` encodes 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes. Bit i of `tx_mask` stands for byte `tx_base`+i, and mask bits at or above the segment size are 0.
- R11: Address bits below the word size (2 low bits for W=4, 3 for W=8) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | NTHR*AW | Byte address per thread; thread i in bits [i*AW +: AW] |
| req_act | input | NTHR | Per-thread active flag |
| req_wide | input | 1 | Word size: 0 = 4 bytes, 1 = 8 bytes |
| req_relaxed | input | 1 | 0 = strict grouping, 1 = relaxed grouping |
| tx_valid | output | 1 | Transaction present |
| tx_ready | input | 1 | Memory side takes the transaction |
| tx_base | output | AW | Segment base byte address |
| tx_size | output | 2 | Segment size code |
| tx_mask | output | 128 | Requested bytes relative to `tx_base` |
| done | output | 1 | Request fully issued |

## Verification
The first transaction of a request is due in the cycle right after the acceptance edge. Each later one is due in the cycle after the handshake that retired the one before it. The completion pulse follows the last handshake by one cycle, or the acceptance edge by one cycle for an empty request. The bench's reference model builds the full expected transaction list when the request is accepted. It advances that list only on the handshakes it drives itself. On every falling clock edge it compares the ready, valid, done and transaction outputs with the model's state. Every cycle of the stalls caused by the pseudo-random `tx_ready` is therefore checked too.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int SEG_BYTES = 128;
    localparam int SEG_LSB   = 7;

    typedef enum logic [1:0] {
        SEG_32  = 2'd0,
        SEG_64  = 2'd1,
        SEG_128 = 2'd2
    } seg_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_e;
endpackage

// File: rtl/coal_align.sv
// Detects the single-transaction pattern of the strict rule on cleaned addresses.
module coal_align #(
    parameter int NTHR = 16,
    parameter int AW   = 32
) (
    input  logic [NTHR-1:0][AW-1:0] addr_i,
    input  logic [NTHR-1:0]         act_i,
    input  logic                    wide_i,
    output logic                    ok_o,
    output logic [AW-1:0]           base_o
);
    always_comb begin
        logic          found;
        int            lw;
        logic [AW-1:0] amask;
        found  = 1'b0;
        lw     = wide_i ? 3 : 2;
        base_o = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (act_i[i] && !found) begin
                found  = 1'b1;
                base_o = addr_i[i] - (AW'(i) << lw);
            end
        end
        amask = (AW'(NTHR) << lw) - AW'(1);
        ok_o  = found && ((base_o & amask) == '0);
        for (int k = 0; k < NTHR; k++) begin
            if (act_i[k] && (addr_i[k] != base_o + (AW'(k) << lw)))
                ok_o = 1'b0;
        end
    end
endmodule

// File: rtl/coal_lead.sv
// Picks the pending thread with the lowest address; lowest index wins ties.
module coal_lead #(
    parameter int NTHR = 16,
    parameter int AW   = 32
) (
    input  logic [NTHR-1:0][AW-1:0] addr_i,
    input  logic [NTHR-1:0]         pend_i,
    output logic [$clog2(NTHR)-1:0] idx_o,
    output logic [AW-1:0]           addr_o
);
    localparam int IW = $clog2(NTHR);

    always_comb begin
        logic found;
        found  = 1'b0;
        idx_o  = '0;
        addr_o = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (pend_i[i] && (!found || addr_i[i] < addr_o)) begin
                found  = 1'b1;
                addr_o = addr_i[i];
                idx_o  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/coal_group.sv
// Forms the current transaction and the set of threads it retires.
module coal_group
    import coal_pkg::*;
#(
    parameter int NTHR = 16,
    parameter int AW   = 32
) (
    input  logic [NTHR-1:0][AW-1:0] addr_i,
    input  logic [NTHR-1:0]         pend_i,
    input  logic [$clog2(NTHR)-1:0] lead_idx_i,
    input  logic [AW-1:0]           lead_addr_i,
    input  logic                    wide_i,
    input  logic                    relaxed_i,
    input  logic                    coal_i,
    input  logic [AW-1:0]           cbase_i,
    output logic [AW-1:0]           base_o,
    output seg_e                    size_o,
    output logic [SEG_BYTES-1:0]    mask_o,
    output logic [NTHR-1:0]         take_o
);
    localparam int NB = SEG_BYTES;
    localparam int QB = NB / 4;

    always_comb begin
        logic [NB-1:0] wfill;
        logic [AW-1:0] blk;
        logic [3:0]    occ;
        int            ws;
        int            qsel;
        ws     = wide_i ? 8 : 4;
        wfill  = wide_i ? NB'(8'hFF) : NB'(8'h0F);
        blk    = {lead_addr_i[AW-1:SEG_LSB], {SEG_LSB{1'b0}}};
        mask_o = '0;
        take_o = '0;
        base_o = '0;
        size_o = SEG_32;
        occ    = '0;
        qsel   = 0;
        if (!relaxed_i && coal_i) begin
            base_o = cbase_i;
            size_o = wide_i ? SEG_128 : SEG_64;
            take_o = pend_i;
            for (int i = 0; i < NTHR; i++)
                if (pend_i[i]) mask_o = mask_o | (wfill << (i * ws));
        end else if (!relaxed_i) begin
            base_o = {lead_addr_i[AW-1:5], 5'b0};
            size_o = SEG_32;
            take_o[lead_idx_i] = 1'b1;
            mask_o = wfill << lead_addr_i[4:0];
        end else begin
            for (int i = 0; i < NTHR; i++) begin
                if (pend_i[i] && addr_i[i][AW-1:SEG_LSB] == lead_addr_i[AW-1:SEG_LSB]) begin
                    take_o[i] = 1'b1;
                    mask_o    = mask_o | (wfill << addr_i[i][SEG_LSB-1:0]);
                end
            end
            for (int q = 0; q < 4; q++) begin
                occ[q] = |mask_o[q*QB +: QB];
                if (occ[q]) qsel = q;
            end
            if ($countones(occ) == 1) begin
                size_o = SEG_32;
                base_o = blk + AW'(qsel * QB);
                mask_o = mask_o >> (qsel * QB);
            end else if (occ[3:2] == 2'b00) begin
                size_o = SEG_64;
                base_o = blk;
            end else if (occ[1:0] == 2'b00) begin
                size_o = SEG_64;
                base_o = blk + AW'(2 * QB);
                mask_o = mask_o >> (2 * QB);
            end else begin
                size_o = SEG_128;
                base_o = blk;
            end
        end
    end
endmodule

// File: rtl/coal_top.sv
module coal_top
    import coal_pkg::*;
#(
    parameter int NTHR = 16,
    parameter int AW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [NTHR*AW-1:0]   req_addr,
    input  logic [NTHR-1:0]      req_act,
    input  logic                 req_wide,
    input  logic                 req_relaxed,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [AW-1:0]        tx_base,
    output logic [1:0]           tx_size,
    output logic [SEG_BYTES-1:0] tx_mask,
    output logic                 done
);
    localparam int IW = $clog2(NTHR);

    typedef struct packed {
        state_e                  st;
        logic [NTHR-1:0][AW-1:0] addr;
        logic [NTHR-1:0]         pend;
        logic                    wide;
        logic                    relaxed;
        logic                    coal;
        logic [AW-1:0]           cbase;
    } regs_t;

    regs_t r_d, r_q;

    logic [NTHR-1:0][AW-1:0] in_addr;
    logic                    al_ok;
    logic [AW-1:0]           al_base;
    logic [IW-1:0]           ld_idx;
    logic [AW-1:0]           ld_addr;
    logic [AW-1:0]           gp_base;
    seg_e                    gp_size;
    logic [SEG_BYTES-1:0]    gp_mask;
    logic [NTHR-1:0]         gp_take;

    // R11: word-offset bits are cleared before anything looks at them
    always_comb begin
        for (int i = 0; i < NTHR; i++)
            in_addr[i] = req_addr[i*AW +: AW] & ~(req_wide ? AW'(7) : AW'(3));
    end

    coal_align #(.NTHR(NTHR), .AW(AW)) i_align (
        .addr_i (in_addr),
        .act_i  (req_act),
        .wide_i (req_wide),
        .ok_o   (al_ok),
        .base_o (al_base)
    );

    coal_lead #(.NTHR(NTHR), .AW(AW)) i_lead (
        .addr_i (r_q.addr),
        .pend_i (r_q.pend),
        .idx_o  (ld_idx),
        .addr_o (ld_addr)
    );

    coal_group #(.NTHR(NTHR), .AW(AW)) i_group (
        .addr_i      (r_q.addr),
        .pend_i      (r_q.pend),
        .lead_idx_i  (ld_idx),
        .lead_addr_i (ld_addr),
        .wide_i      (r_q.wide),
        .relaxed_i   (r_q.relaxed),
        .coal_i      (r_q.coal),
        .cbase_i     (r_q.cbase),
        .base_o      (gp_base),
        .size_o      (gp_size),
        .mask_o      (gp_mask),
        .take_o      (gp_take)
    );

    always_comb begin
        r_d       = r_q;
        req_ready = 1'b0;
        tx_valid  = 1'b0;
        done      = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.st      = ST_BUSY;
                    r_d.addr    = in_addr;
                    r_d.pend    = req_act;
                    r_d.wide    = req_wide;
                    r_d.relaxed = req_relaxed;
                    r_d.coal    = al_ok;
                    r_d.cbase   = al_base;
                end
            end
            default: begin
                if (|r_q.pend) begin
                    tx_valid = 1'b1;
                    if (tx_ready) r_d.pend = r_q.pend & ~gp_take;
                end else begin
                    done   = 1'b1;
                    r_d.st = ST_IDLE;
                end
            end
        endcase
    end

    assign tx_base = gp_base;
    assign tx_size = gp_size;
    assign tx_mask = gp_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !req_ready);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_base) && $stable(tx_size) && $stable(tx_mask)));

    // R9
    done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tx_valid && !req_ready));

    // R9
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));

    // R10
    seg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_size == 2'd0 && tx_base[4:0] == 5'd0) ||
                      (tx_size == 2'd1 && tx_base[5:0] == 6'd0) ||
                      (tx_size == 2'd2 && tx_base[6:0] == 7'd0)));

    // R10
    mask_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_mask != '0 &&
                      (tx_size != 2'd0 || tx_mask[SEG_BYTES-1:32] == '0) &&
                      (tx_size != 2'd1 || tx_mask[SEG_BYTES-1:64] == '0)));

    // R4
    per_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !r_q.relaxed && !r_q.coal) |->
            (tx_size == 2'd0 && $countones(tx_mask) == (r_q.wide ? 8 : 4)));

    // R6
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_valid || tx_base >= $past(tx_base)));
endmodule

// File: tb/test_coal_top.sv
`timescale 1ns/1ps
module test_coal_top;
    localparam int NTHR = 16;
    localparam int AW   = 32;

    typedef struct {
        logic [31:0]  base;
        logic [1:0]   size;
        logic [127:0] mask;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [NTHR*AW-1:0]   req_addr = '0;
    logic [NTHR-1:0]      req_act = '0;
    logic                 req_wide = 1'b0;
    logic                 req_relaxed = 1'b0;
    logic                 tx_valid;
    logic                 tx_ready = 1'b0;
    logic [AW-1:0]        tx_base;
    logic [1:0]           tx_size;
    logic [127:0]         tx_mask;
    logic                 done;

    int    nvec = 0;
    int    nfail = 0;
    exp_t  q[$];
    bit    mbusy = 0;
    bit    have_req = 0;
    bit    stalled = 0;
    bit    bp = 0;
    logic [15:0] lfsr = 16'hACE1;
    string cur_tag = "R2";

    logic [31:0] g_addr [NTHR];
    logic [15:0] g_act;
    logic        g_wide;
    logic        g_rel;

    always #2 clk = ~clk;

    coal_top #(.NTHR(NTHR), .AW(AW)) i_coal_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_act(req_act), .req_wide(req_wide),
        .req_relaxed(req_relaxed), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_base(tx_base), .tx_size(tx_size), .tx_mask(tx_mask), .done(done)
    );

    task automatic push(input logic [31:0] b, input logic [1:0] s, input logic [127:0] m);
        exp_t e;
        e.base = b; e.size = s; e.mask = m;
        q.push_back(e);
    endtask

    // Expected transaction list, written from the requirements
    task automatic build();
        int          ws;
        logic [31:0] a [NTHR];
        bit          pend [NTHR];
        bit          ok;
        int          j;
        logic [31:0] bb;
        logic [127:0] m;
        ws = g_wide ? 8 : 4;
        for (int i = 0; i < NTHR; i++) begin
            a[i] = g_addr[i] & ~(32'(ws) - 32'd1);
            pend[i] = g_act[i];
        end
        ok = 0;
        if (!g_rel) begin
            j = -1;
            for (int i = 0; i < NTHR; i++) if (g_act[i] && j < 0) j = i;
            if (j >= 0) begin
                bb = a[j] - 32'(j * ws);
                ok = (bb % 32'(16 * ws)) == 0;
                for (int k = 0; k < NTHR; k++)
                    if (g_act[k] && a[k] != bb + 32'(k * ws)) ok = 0;
                if (ok) begin
                    m = '0;
                    for (int k = 0; k < NTHR; k++)
                        if (g_act[k]) for (int b = 0; b < ws; b++) m[k*ws+b] = 1'b1;
                    push(bb, g_wide ? 2'd2 : 2'd1, m);
                end
            end
            if (!ok) begin
                forever begin
                    int best;
                    best = -1;
                    for (int i = 0; i < NTHR; i++)
                        if (pend[i] && (best < 0 || a[i] < a[best])) best = i;
                    if (best < 0) break;
                    m = '0;
                    for (int b = 0; b < ws; b++) m[int'(a[best] % 32) + b] = 1'b1;
                    push(a[best] & ~32'd31, 2'd0, m);
                    pend[best] = 0;
                end
            end
        end else begin
            forever begin
                int best;
                logic [31:0] blk;
                bit [3:0] occ;
                best = -1;
                for (int i = 0; i < NTHR; i++)
                    if (pend[i] && (best < 0 || a[i] < a[best])) best = i;
                if (best < 0) break;
                blk = a[best] & ~32'd127;
                m = '0;
                for (int i = 0; i < NTHR; i++) begin
                    if (pend[i] && (a[i] & ~32'd127) == blk) begin
                        for (int b = 0; b < ws; b++) m[int'(a[i] - blk) + b] = 1'b1;
                        pend[i] = 0;
                    end
                end
                for (int qq = 0; qq < 4; qq++) occ[qq] = |m[qq*32 +: 32];
                if (occ == 4'b0001 || occ == 4'b0010 || occ == 4'b0100 || occ == 4'b1000) begin
                    int qs;
                    qs = 0;
                    for (int qq = 0; qq < 4; qq++) if (occ[qq]) qs = qq;
                    push(blk + 32'(qs * 32), 2'd0, m >> (qs * 32));
                end else if (occ[3:2] == 2'b00) push(blk, 2'd1, m);
                else if (occ[1:0] == 2'b00) push(blk + 32'd64, 2'd1, m >> 64);
                else push(blk, 2'd2, m);
            end
        end
    endtask

    task automatic fail_line(input string tag, input logic [31:0] eb, input logic [1:0] es,
                             input logic [127:0] em, input logic ev, input logic ed);
        nfail++;
        $display("FAIL %s: got rdy=%b v=%b d=%b base=%h size=%0d mask=%h ; expected v=%b d=%b base=%h size=%0d mask=%h",
                 tag, req_ready, tx_valid, done, tx_base, tx_size, tx_mask, ev, ed, eb, es, em);
    endtask

    task automatic step();
        bit rdy;
        bit take;
        @(negedge clk);
        nvec++;
        if (!mbusy) begin
            // R2: idle outputs
            if (req_ready !== 1'b1 || tx_valid !== 1'b0 || done !== 1'b0)
                fail_line("R2", '0, '0, '0, 1'b0, 1'b0);
        end else if (q.size() > 0) begin
            if (tx_valid !== 1'b1 || done !== 1'b0 || req_ready !== 1'b0 ||
                tx_base !== q[0].base || tx_size !== q[0].size || tx_mask !== q[0].mask)
                fail_line(stalled ? "R8" : cur_tag, q[0].base, q[0].size, q[0].mask, 1'b1, 1'b0);
        end else begin
            // R9: completion pulse
            if (done !== 1'b1 || tx_valid !== 1'b0 || req_ready !== 1'b0)
                fail_line("R9", '0, '0, '0, 1'b0, 1'b1);
        end
        rdy  = bp ? lfsr[0] : 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = rdy;
        take = !mbusy && have_req;
        stalled = 0;
        if (mbusy) begin
            if (q.size() > 0) begin
                if (rdy) void'(q.pop_front());
                else stalled = 1;
            end else mbusy = 0;
        end
        if (take) begin
            req_valid   = 1'b1;
            for (int i = 0; i < NTHR; i++) req_addr[i*AW +: AW] = g_addr[i];
            req_act     = g_act;
            req_wide    = g_wide;
            req_relaxed = g_rel;
            build();
            mbusy    = 1;
            have_req = 0;
        end else begin
            req_valid = 1'b0;
            req_act   = 16'hFFFF;
            req_addr  = {NTHR{32'hBAD0_0004}};
        end
    endtask

    task automatic run_req(input logic [15:0] act, input logic wide, input logic rel, input string tag);
        g_act = act; g_wide = wide; g_rel = rel;
        cur_tag  = tag;
        have_req = 1;
        step();
        while (have_req || mbusy) step();
        step();
    endtask

    initial begin
        #(4 * 190000);
        nfail++;
        $display("FAIL watchdog: run did not finish; expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        nvec++;
        if (req_ready !== 1'b1 || tx_valid !== 1'b0 || done !== 1'b0)
            fail_line("R1", '0, '0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        nvec++;
        if (req_ready !== 1'b1 || tx_valid !== 1'b0 || done !== 1'b0)
            fail_line("R1", '0, '0, '0, 1'b0, 1'b0);

        // R3: aligned sequential 4-byte and 8-byte words
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h1000 + 32'(4 * i);
        run_req(16'hFFFF, 1'b0, 1'b0, "R3");
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h2000 + 32'(8 * i);
        run_req(16'hFFFF, 1'b1, 1'b0, "R3");

        // R7: inactive threads with wild addresses do not break the match
        for (int i = 0; i < NTHR; i++) g_addr[i] = (i >= 4 && i < 8) ? 32'h3000 + 32'(4 * i) : 32'hDEAD_0000 + 32'(i);
        run_req(16'h00F0, 1'b0, 1'b0, "R7");
        run_req(16'h0000, 1'b0, 1'b0, "R7");
        run_req(16'h0000, 1'b1, 1'b1, "R7");

        bp = 1;
        // R4: misaligned and strided fall back per thread
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h1004 + 32'(4 * i);
        run_req(16'hFFFF, 1'b0, 1'b0, "R4");
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h1000 + 32'(8 * i);
        run_req(16'hFFFF, 1'b0, 1'b0, "R4");

        // R5: relaxed grouping of the same patterns
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h1044 + 32'(4 * i);
        run_req(16'hFFFF, 1'b0, 1'b1, "R5");
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h1000 + 32'(8 * i);
        run_req(16'hFFFF, 1'b0, 1'b1, "R5");
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h9000 + 32'(((i * 7) % 5) * 48);
        run_req(16'hF7FF, 1'b1, 1'b1, "R5");

        // R6: descending thread addresses, repeated addresses in strict mode
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h5000 + 32'((15 - i) * 64);
        run_req(16'hFFFF, 1'b0, 1'b1, "R6");
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h6000 + 32'(((15 - i) / 2) * 4);
        run_req(16'hFFFF, 1'b0, 1'b0, "R6");

        // R11: low address bits below the word size
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h1000 + 32'(4 * i) + 32'(i % 4);
        run_req(16'hFFFF, 1'b0, 1'b0, "R11");
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h2000 + 32'(8 * i) + 32'd5;
        run_req(16'hFFFF, 1'b1, 1'b0, "R11");

        // R10: relaxed shrink to a 32-byte quarter and an upper 64-byte half
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h7060 + 32'(8 * i);
        run_req(16'h000F, 1'b1, 1'b1, "R10");
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h7050 + 32'(4 * i);
        run_req(16'h1FFF, 1'b0, 1'b1, "R10");

        // R8: heavy stall on a long per-thread sequence
        for (int i = 0; i < NTHR; i++) g_addr[i] = 32'h8000 + 32'(i * 100);
        run_req(16'hFFFF, 1'b1, 1'b0, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule